// File: doc/BRIEF.md
# Test Access Port with Debug Run-Control Instructions

This block is a test access port clocked by TCK. It runs the sixteen-state TAP state machine from TMS and can be forced into Test-Logic-Reset at any time by an asynchronous active-high TRST. A 4-bit instruction register is loaded serially from TDI. The decoded instruction chooses which data register sits between TDI and TDO: a 32-bit identification register, a one-bit bypass register, or an external boundary-scan chain reached through a serial-return input.

Besides the boundary-scan instructions, four run-control opcodes produce request signals for a debug controller placed elsewhere:

- Halt, resume and target reset are levels that stay high while their instruction is held.
- Step is a single-TCK pulse, raised in the Update-IR state in which a step instruction has just been installed.

For the external chain, the block provides capture, shift and update strobes and an enable. The chain cells themselves and any clock gating sit outside the block.

Top module: `dbg_tap`

## Requirements
- R1: Asserting `trst` at any time immediately puts the TAP in Test-Logic-Reset, makes 0001 (IDCODE) the active instruction, drives `tdo` to 0 and clears all request outputs and `bsc_enable`.
- R2: Five consecutive TCK rising edges with TMS high reach Test-Logic-Reset from any state, and the active instruction becomes IDCODE (0001).
- R3: On entering Shift-IR, the IR shift stage holds 0001, which leaves on `tdo` least significant bit first. The opcode enters from `tdi` least significant bit first, and its last bit is taken on the edge on which TMS=1 moves the TAP to Exit1-IR.
- R4: A newly shifted opcode has no effect on any output until the TAP enters Update-IR.
- R5: With IDCODE (0001) active, Capture-DR loads the 32-bit identification value, which then shifts out on `tdo` least significant bit first.
- R6: BYPASS (1111), CLAMP (0101), HALT (0110), STEP (0111), RESUME (1000), RESET (1001) and every undefined opcode (0000, 1010 to 1110) place the one-bit bypass register in the path. It captures 0, so TDO gives 0 followed by TDI delayed by one bit.
- R7: SAMPLE_PRELOAD (0010), EXTEST (0011) and INTEST (0100) place the external chain in the path: `tdo` follows `bsc_so`. `bsc_capture`, `bsc_shift` and `bsc_update` are high in Capture-DR, Shift-DR and Update-DR, and only under these opcodes.
- R8: `bsc_enable` is high exactly while the active opcode is 0010, 0011, 0100 or 0101.
- R9: `halt_req`, `resume_req` and `reset_req` are high exactly while the active opcode is 0110, 1000 or 1001 respectively.
- R10: `step_req` is high for exactly one TCK cycle, in the Update-IR state that installs opcode 0111, and at no other time.
- R11: `tdo` changes only on falling TCK edges and is 0 in every state other than Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Asynchronous test reset, active high |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| bsc_so | input | 1 | Serial return from the external boundary-scan chain |
| bsc_capture | output | 1 | Chain capture strobe |
| bsc_shift | output | 1 | Chain shift strobe |
| bsc_update | output | 1 | Chain update strobe |
| bsc_enable | output | 1 | A boundary-scan instruction is active |
| halt_req | output | 1 | Halt request level |
| step_req | output | 1 | One-cycle step request |
| resume_req | output | 1 | Resume request level |
| reset_req | output | 1 | Target reset request level |

## Verification
Two things happen in the same Update-IR cycle: a new instruction becomes active, and the step pulse is judged against that new instruction rather than the one it replaces. The bench sweeps all sixteen opcodes through full IR scans, so every previous-to-next pair along the sweep appears. It then repeats STEP back to back and follows STEP with HALT. At the Update-IR cycle it checks that the pulse appears exactly when the incoming opcode is 0111, and that the request levels have switched in that same cycle and not earlier, at Exit1-IR.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W = 4;
    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_IDCODE  = 4'b0001;
    localparam opcode_t OP_SAMPLE  = 4'b0010;
    localparam opcode_t OP_EXTEST  = 4'b0011;
    localparam opcode_t OP_INTEST  = 4'b0100;
    localparam opcode_t OP_CLAMP   = 4'b0101;
    localparam opcode_t OP_HALT    = 4'b0110;
    localparam opcode_t OP_STEP    = 4'b0111;
    localparam opcode_t OP_RESUME  = 4'b1000;
    localparam opcode_t OP_TRESET  = 4'b1001;
    localparam opcode_t OP_BYPASS  = 4'b1111;
    localparam opcode_t IR_CAPTURE = 4'b0001;

    typedef struct packed {
        logic sel_id;
        logic sel_chain;
        logic bsc_en;
        logic halt;
        logic step;
        logic resume;
        logic treset;
    } ir_dec_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
            default:   n = m ? ST_SEL_DR : ST_RTI;
        endcase
        return n;
    endfunction

    function automatic ir_dec_t ir_decode(input opcode_t op);
        ir_dec_t d;
        d = '0;
        case (op)
            OP_IDCODE: d.sel_id = 1'b1;
            OP_SAMPLE, OP_EXTEST, OP_INTEST: begin
                d.sel_chain = 1'b1;
                d.bsc_en    = 1'b1;
            end
            OP_CLAMP:  d.bsc_en = 1'b1;
            OP_HALT:   d.halt   = 1'b1;
            OP_STEP:   d.step   = 1'b1;
            OP_RESUME: d.resume = 1'b1;
            OP_TRESET: d.treset = 1'b1;
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_d
);
    assign state_d = tap_next(state_q, tms);

    always_ff @(posedge tck or posedge trst) begin
        if (trst) state_q <= ST_TLR;
        else      state_q <= state_d;
    end
endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  tap_state_e state_q,
    input  tap_state_e state_d,
    input  logic       tdi,
    output opcode_t    ir_q,
    output logic       ir_sout
);
    opcode_t ir_sr;

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            ir_sr <= IR_CAPTURE;
            ir_q  <= OP_IDCODE;
        end else begin
            case (state_q)
                ST_CAP_IR: ir_sr <= IR_CAPTURE;
                ST_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                default:   ir_sr <= ir_sr;
            endcase
            if (state_d == ST_TLR)
                ir_q <= OP_IDCODE;
            else if (state_d == ST_UPD_IR)
                ir_q <= ir_sr;
        end
    end

    assign ir_sout = ir_sr[0];
endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_3E07
) (
    input  logic       tck,
    input  logic       trst,
    input  tap_state_e state_q,
    input  ir_dec_t    dec,
    input  logic       tdi,
    input  logic       bsc_so,
    output logic       dr_sout
);
    logic [ID_W-1:0] id_sr;
    logic            byp_q;

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            id_sr <= ID_VALUE[ID_W-1:0];
            byp_q <= 1'b0;
        end else begin
            if (dec.sel_id) begin
                if (state_q == ST_CAP_DR)      id_sr <= ID_VALUE[ID_W-1:0];
                else if (state_q == ST_SHF_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
            end
            if (!dec.sel_id && !dec.sel_chain) begin
                if (state_q == ST_CAP_DR)      byp_q <= 1'b0;
                else if (state_q == ST_SHF_DR) byp_q <= tdi;
            end
        end
    end

    always_comb begin
        if (dec.sel_id)         dr_sout = id_sr[0];
        else if (dec.sel_chain) dr_sout = bsc_so;
        else                    dr_sout = byp_q;
    end
endmodule

// File: rtl/dbg_tap.sv
module dbg_tap
    import dbg_tap_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_3E07
) (
    input  logic tck,
    input  logic trst,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    input  logic bsc_so,
    output logic bsc_capture,
    output logic bsc_shift,
    output logic bsc_update,
    output logic bsc_enable,
    output logic halt_req,
    output logic step_req,
    output logic resume_req,
    output logic reset_req
);
    tap_state_e state_q, state_d;
    opcode_t    ir_q;
    ir_dec_t    dec;
    logic       ir_sout, dr_sout, tdo_q;

    dbg_tap_fsm i_fsm (
        .tck(tck), .trst(trst), .tms(tms), .state_q(state_q), .state_d(state_d)
    );

    dbg_tap_ir i_ir (
        .tck(tck), .trst(trst), .state_q(state_q), .state_d(state_d),
        .tdi(tdi), .ir_q(ir_q), .ir_sout(ir_sout)
    );

    assign dec = ir_decode(ir_q);

    dbg_tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) i_dr (
        .tck(tck), .trst(trst), .state_q(state_q), .dec(dec),
        .tdi(tdi), .bsc_so(bsc_so), .dr_sout(dr_sout)
    );

    always_ff @(negedge tck or posedge trst) begin
        if (trst) tdo_q <= 1'b0;
        else begin
            case (state_q)
                ST_SHF_IR: tdo_q <= ir_sout;
                ST_SHF_DR: tdo_q <= dr_sout;
                default:   tdo_q <= 1'b0;
            endcase
        end
    end

    assign tdo         = tdo_q;
    assign bsc_capture = dec.sel_chain && (state_q == ST_CAP_DR);
    assign bsc_shift   = dec.sel_chain && (state_q == ST_SHF_DR);
    assign bsc_update  = dec.sel_chain && (state_q == ST_UPD_DR);
    assign bsc_enable  = dec.bsc_en;
    assign halt_req    = dec.halt;
    assign resume_req  = dec.resume;
    assign reset_req   = dec.treset;
    assign step_req    = dec.step && (state_q == ST_UPD_IR);
endmodule

// File: rtl/dbg_tap_chk.sv
module dbg_tap_chk
    import dbg_tap_pkg::*;
(
    input logic       tck,
    input logic       trst,
    input logic       tms,
    input tap_state_e state_q,
    input opcode_t    ir_q,
    input logic       tdo,
    input logic       bsc_enable,
    input logic       halt_req,
    input logic       step_req,
    input logic       resume_req,
    input logic       reset_req
);
    logic [2:0] ones_cnt;

    always_ff @(posedge tck or posedge trst) begin
        if (trst)          ones_cnt <= '0;
        else if (!tms)     ones_cnt <= '0;
        else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
    end

    assert_tms_reset_R2: assert property (@(posedge tck) disable iff (trst)
        (ones_cnt >= 3'd5) |-> (state_q == ST_TLR));

    assert_ir_update_R4: assert property (@(posedge tck) disable iff (trst)
        !$stable(ir_q) |-> (state_q == ST_UPD_IR || state_q == ST_TLR));

    assert_req_onehot_R9: assert property (@(posedge tck) disable iff (trst)
        $onehot0({halt_req, step_req, resume_req, reset_req}));

    assert_step_pulse_R10: assert property (@(posedge tck) disable iff (trst)
        step_req |=> !step_req);

    assert_step_state_R10: assert property (@(posedge tck) disable iff (trst)
        step_req |-> (state_q == ST_UPD_IR));

    assert_bsc_not_debug_R8: assert property (@(posedge tck) disable iff (trst)
        bsc_enable |-> !(halt_req || step_req || resume_req || reset_req));

    assert_tdo_idle_R11: assert property (@(posedge tck) disable iff (trst)
        (state_q != ST_SHF_IR && state_q != ST_SHF_DR) |-> (tdo == 1'b0));
endmodule

bind dbg_tap dbg_tap_chk i_chk (
    .tck(tck), .trst(trst), .tms(tms), .state_q(state_q), .ir_q(ir_q),
    .tdo(tdo), .bsc_enable(bsc_enable), .halt_req(halt_req),
    .step_req(step_req), .resume_req(resume_req), .reset_req(reset_req)
);

// File: tb/test_dbg_tap.sv
module test_dbg_tap;
    localparam logic [31:0] TB_ID = 32'h2B6D_4F13;

    logic tck = 1'b0;
    logic trst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic bsc_so = 1'b1;
    logic tdo, bsc_capture, bsc_shift, bsc_update, bsc_enable;
    logic halt_req, step_req, resume_req, reset_req;

    int checks = 0;
    int errors = 0;
    logic [3:0] cur_op = 4'b0001;
    bit done = 0;

    always #10 tck = ~tck;

    dbg_tap #(.ID_W(32), .ID_VALUE(TB_ID)) i_dbg_tap (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo),
        .bsc_so(bsc_so), .bsc_capture(bsc_capture), .bsc_shift(bsc_shift),
        .bsc_update(bsc_update), .bsc_enable(bsc_enable),
        .halt_req(halt_req), .step_req(step_req),
        .resume_req(resume_req), .reset_req(reset_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_lvl(input logic [3:0] op);
        return {op == 4'd6, op == 4'd8, op == 4'd9};
    endfunction

    function automatic logic exp_bsc(input logic [3:0] op);
        return (op >= 4'd2 && op <= 4'd5);
    endfunction

    function automatic logic exp_chain(input logic [3:0] op);
        return (op >= 4'd2 && op <= 4'd4);
    endfunction

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        #2;
        o   = tdo;
        tms = m;
        tdi = d;
        @(posedge tck);
        #2;
    endtask

    task automatic ir_scan(input logic [3:0] op);
        logic o;
        logic [3:0] cap;
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, op[i], o);
            cap[i] = o;
        end
        chk(cap == 4'b0001, "R3 capture pattern", {28'd0, cap}, 32'h1);
        chk({halt_req, resume_req, reset_req} == exp_lvl(cur_op) && !step_req
            && bsc_enable == exp_bsc(cur_op), "R4 no effect before Update-IR",
            {28'd0, halt_req, resume_req, reset_req, bsc_enable},
            {28'd0, exp_lvl(cur_op), exp_bsc(cur_op)});
        tick(1, 0, o);
        chk(step_req == (op == 4'd7), "R10 step in Update-IR", {31'd0, step_req}, {31'd0, op == 4'd7});
        chk({halt_req, resume_req, reset_req} == exp_lvl(op), "R9 levels",
            {29'd0, halt_req, resume_req, reset_req}, {29'd0, exp_lvl(op)});
        tick(0, 0, o);
        chk(!step_req, "R10 step one cycle", {31'd0, step_req}, 32'd0);
        chk(bsc_enable == exp_bsc(op), "R8 enable", {31'd0, bsc_enable}, {31'd0, exp_bsc(op)});
        cur_op = op;
    endtask

    task automatic dr_scan(input int n, input logic [31:0] pat, output logic [31:0] got);
        logic o;
        logic ch;
        ch  = exp_chain(cur_op);
        got = '0;
        tick(1, 0, o);
        tick(0, 0, o);
        chk(bsc_capture == ch, "R7 capture strobe", {31'd0, bsc_capture}, {31'd0, ch});
        tick(0, 0, o);
        chk(bsc_shift == ch, "R7 shift strobe", {31'd0, bsc_shift}, {31'd0, ch});
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, pat[i], o);
            got[i] = o;
            if (i < n - 1)
                chk(tdo == o, "R11 tdo stable at rising edge", {31'd0, tdo}, {31'd0, o});
        end
        tick(1, 0, o);
        chk(bsc_update == ch, "R7 update strobe", {31'd0, bsc_update}, {31'd0, ch});
        tick(0, 0, o);
        chk(tdo == 1'b0, "R11 tdo idle", {31'd0, tdo}, 32'd0);
    endtask

    task automatic check_path8(input string tag);
        logic [31:0] got;
        logic [7:0] pat, exp;
        pat = 8'hB4 ^ {4'd0, cur_op};
        dr_scan(8, {24'd0, pat}, got);
        if (cur_op == 4'd1)          exp = TB_ID[7:0];
        else if (exp_chain(cur_op))  exp = 8'hFF;
        else                         exp = {pat[6:0], 1'b0};
        chk(got[7:0] == exp, tag, got, {24'd0, exp});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic o;
        logic [31:0] got;
        #45;
        chk(tdo == 1'b0 && !halt_req && !step_req && !resume_req && !reset_req && !bsc_enable,
            "R1 reset outputs", {27'd0, tdo, halt_req, step_req, resume_req, reset_req}, 32'd0);
        @(negedge tck);
        trst = 1'b0;
        tick(0, 0, o);
        dr_scan(32, 32'h0, got);
        chk(got == TB_ID, "R5 identification value", got, TB_ID);

        for (int k = 0; k < 16; k++) begin
            ir_scan(k[3:0]);
            if (exp_chain(k[3:0]))      check_path8("R7 chain path");
            else if (k == 1)            check_path8("R5 id path");
            else                        check_path8("R6 bypass path");
        end

        ir_scan(4'd7);
        ir_scan(4'd7);
        ir_scan(4'd6);
        chk(halt_req, "R9 halt held", {31'd0, halt_req}, 32'd1);

        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 5; i++) tick(1, 0, o);
        chk(!halt_req, "R2 tms reset from Shift-DR", {31'd0, halt_req}, 32'd0);
        cur_op = 4'd1;
        tick(0, 0, o);
        check_path8("R2 IDCODE after tms reset");

        ir_scan(4'd8);
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 5; i++) tick(1, 1, o);
        chk(!resume_req, "R2 tms reset from Shift-IR", {31'd0, resume_req}, 32'd0);
        cur_op = 4'd1;
        tick(0, 0, o);

        ir_scan(4'd9);
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        @(negedge tck);
        #3 trst = 1'b1;
        #1;
        chk(!reset_req && tdo == 1'b0, "R1 async trst", {30'd0, reset_req, tdo}, 32'd0);
        @(negedge tck);
        trst  = 1'b0;
        tms   = 1'b0;
        cur_op = 4'd1;
        tick(0, 0, o);
        check_path8("R1 IDCODE after trst");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule